// File: doc/BRIEF.md
# NAND Flash Command Phase Sequencer

This block drives one 8-bit NAND flash device for a host that has already set up the command bytes, address, data word and timing. A single `go` pulse starts an operation. The operation is built from up to four phases, each switched on by its own enable: a leading command byte, an address burst, a data phase, and a trailing command byte. Phases that are not enabled are skipped. An order flag decides whether the trailing command comes before the data phase (page read) or after it (page program). An erase uses a three-byte address and no data. A device reset uses the leading command byte alone.

During a programmed-I/O receive, up to four bytes are read with RE# strobes and packed into a 32-bit response word, first byte lowest. After the trailing command byte, the sequencer waits for the device ready/busy line to go low and then high again. A programmable limit bounds this wait and raises an error flag if it runs out. All strobe widths come from a timing word and are counted in clock cycles.

At completion the busy indication drops and a done flag is set. The done flag stays set until the host clears it.

Top module: `nand_phase_seq`

## Requirements
- R1: After reset the block is idle: ceN=1, cle=0, ale=0, weN=1, reN=1, ioOe=0, busy=0, done=0, timeoutErr=0.
- R2: With afterData=0, the enabled phases go out in this order: leading command (cmd1), address bytes, trailing command (cmd2), data.
- R3: With afterData=1, the order is: cmd1, address bytes, data, cmd2.
- R4: The address phase sends addrCnt+1 bytes (addrCnt 0..4). The bytes come from the 40-bit value {addrHi, addrLo}, least significant byte first. Each byte is latched with ale=1 and cle=0. Command bytes are latched with cle=1 and ale=0, and transmit data bytes with both low.
- R5: A phase whose enable is low is not issued. An operation with only enCmd1 set latches exactly one byte, with cle=1.
- R6: A receive data phase (dataRx=1) performs xferSize+1 RE# cycles. Received byte k lands in resp[8k+7:8k]. Lanes that receive no byte read zero, because resp is cleared at each start. ioOe is low whenever reN is low.
- R7: busy is high from the edge that accepts go until the operation completes. ceN is low exactly while busy is high. done is set when busy falls and stays set until a doneClr pulse.
- R8: After cmd2 is latched, the block waits for the synchronized R/B# to read low and then high before it starts the next phase or completes. In a read, no RE# falling edge occurs before R/B# has returned high.
- R9: If the R/B# wait lasts timeoutLim+1 cycles, the block sets timeoutErr, skips the remaining phases and completes with done. timeoutErr clears when the next operation starts.
- R10: Timing word fields, each 4 bits and each treated as at least 1: setup [3:0], WE# low [7:4], WE# high [11:8], RE# low [15:12], RE# high [19:16]. The first WE# fall follows ceN low by the setup count. WE# low lasts the WE# low count. Between consecutive WE# strobes, WE# stays high for the WE# high count plus the setup count. RE# low lasts the RE# low count. ioOut is stable while weN is low.
- R11: devReady is rbN passed through a two-flop synchronizer. It changes on the second clock edge after rbN changes.
- R12: A go pulse while busy is high is ignored and does not start a second operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse, accepted only when idle |
| enCmd1 | input | 1 | Enable the leading command phase |
| enAddr | input | 1 | Enable the address phase |
| enData | input | 1 | Enable the data phase |
| enCmd2 | input | 1 | Enable the trailing command phase |
| afterData | input | 1 | 1: trailing command after data; 0: before data |
| dataRx | input | 1 | 1: data phase reads; 0: data phase writes |
| addrCnt | input | 3 | Address bytes minus one |
| xferSize | input | 2 | Data bytes minus one |
| cmd1 | input | 8 | Leading command byte |
| cmd2 | input | 8 | Trailing command byte |
| addrLo | input | 32 | Column (15:0) and low page bits (31:16) |
| addrHi | input | 8 | Upper page bits |
| txData | input | 32 | Transmit bytes, byte 0 sent first |
| timing | input | 20 | Strobe width fields in cycles |
| timeoutLim | input | 16 | R/B# wait limit in cycles |
| doneClr | input | 1 | Clears the done flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation completed flag |
| timeoutErr | output | 1 | R/B# wait expired |
| devReady | output | 1 | Synchronized R/B# (1 = ready) |
| resp | output | 32 | Packed receive bytes |
| ceN | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| weN | output | 1 | Write enable, active low |
| reN | output | 1 | Read enable, active low |
| ioOut | output | 8 | Byte driven onto the I/O bus |
| ioOe | output | 1 | I/O bus output enable |
| ioIn | input | 8 | Byte read from the I/O bus |
| rbN | input | 1 | Device ready/busy, low = busy |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- CLE and ALE are never high together.
- WE# and RE# are never low together.
- The bus is not driven during RE# low.
- The bus byte holds steady while WE# is low.
- The idle outputs are quiet.
- done persists until doneClr, and a fall of busy always comes with done set.

The bench scenarios cover what needs whole-operation context: phase order for both settings of afterData, address byte order and count, response packing and zeroed lanes, the R/B# low-then-high wait before reads, the timeout path, strobe widths from the timing word, and ignoring go while busy.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [1:0] {PH_CMD1, PH_ADDR, PH_CMD2, PH_DATA} phase_e;
  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WLOW, S_WHIGH, S_RLOW, S_RHIGH, S_BSYLO, S_BSYHI} state_e;
  typedef struct packed {
    logic   clrResp;
    logic   capture;
    phase_e phase;
    logic [2:0] idx;
  } strobe_t;
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int TW  = 4,
  parameter int TOW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            go,
  input  logic            enCmd1,
  input  logic            enAddr,
  input  logic            enData,
  input  logic            enCmd2,
  input  logic            afterData,
  input  logic            dataRx,
  input  logic [2:0]      addrCnt,
  input  logic [1:0]      xferSize,
  input  logic [5*TW-1:0] timing,
  input  logic [TOW-1:0]  timeoutLim,
  input  logic            doneClr,
  input  logic            rdySync,
  output logic            busy,
  output logic            done,
  output logic            timeoutErr,
  output logic            ceN,
  output logic            cle,
  output logic            ale,
  output logic            weN,
  output logic            reN,
  output logic            ioOe,
  output strobe_t         strb
);
  state_e st, stN;
  logic [1:0] step, stepN;
  logic [2:0] idx, idxN;
  logic [TW-1:0] cnt, cntN;
  logic [TOW-1:0] toCnt, toN;
  logic [3:0] stepEn;
  logic firstOk, nxtOk, doneSet, errSet, errClr, clr, cap;
  logic [1:0] firstStep, nxtStep;
  logic [TW-1:0] suL, wpL, whL, rpL, rehL;
  phase_e curPhase;
  logic byteLast, isRead;

  function automatic phase_e phaseAt(input logic [1:0] s, input logic aft);
    case (s)
      2'd0:    return PH_CMD1;
      2'd1:    return PH_ADDR;
      2'd2:    return aft ? PH_DATA : PH_CMD2;
      default: return aft ? PH_CMD2 : PH_DATA;
    endcase
  endfunction

  function automatic logic [TW-1:0] minus1(input logic [TW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  always_comb begin
    suL  = minus1(timing[0*TW +: TW]);
    wpL  = minus1(timing[1*TW +: TW]);
    whL  = minus1(timing[2*TW +: TW]);
    rpL  = minus1(timing[3*TW +: TW]);
    rehL = minus1(timing[4*TW +: TW]);
  end

  always_comb begin
    for (int s = 0; s < 4; s++) begin
      case (phaseAt(2'(s), afterData))
        PH_CMD1: stepEn[s] = enCmd1;
        PH_ADDR: stepEn[s] = enAddr;
        PH_CMD2: stepEn[s] = enCmd2;
        default: stepEn[s] = enData;
      endcase
    end
  end

  always_comb begin
    firstOk = 1'b0; firstStep = 2'd0; nxtOk = 1'b0; nxtStep = 2'd0;
    for (int s = 3; s >= 0; s--) begin
      if (stepEn[s]) begin
        firstOk = 1'b1; firstStep = 2'(s);
      end
      if (stepEn[s] && s > int'(step)) begin
        nxtOk = 1'b1; nxtStep = 2'(s);
      end
    end
  end

  assign curPhase = phaseAt(step, afterData);
  assign isRead   = (curPhase == PH_DATA) && dataRx;
  always_comb begin
    case (curPhase)
      PH_ADDR: byteLast = (idx == addrCnt);
      PH_DATA: byteLast = (idx == {1'b0, xferSize});
      default: byteLast = 1'b1;
    endcase
  end

  always_comb begin
    logic byteDone, advance, doLaunch, finish;
    logic [1:0] launchStep;
    stN = st; stepN = step; idxN = idx; cntN = cnt; toN = toCnt;
    doneSet = 1'b0; errSet = 1'b0; errClr = 1'b0; clr = 1'b0; cap = 1'b0;
    byteDone = 1'b0; advance = 1'b0; doLaunch = 1'b0; finish = 1'b0;
    launchStep = nxtStep;
    case (st)
      S_IDLE: if (go) begin
        clr = 1'b1; errClr = 1'b1;
        if (firstOk) begin doLaunch = 1'b1; launchStep = firstStep; end
        else finish = 1'b1;
      end
      S_SETUP: if (cnt == '0) begin stN = S_WLOW; cntN = wpL; end else cntN = cnt - 1'b1;
      S_WLOW:  if (cnt == '0) begin stN = S_WHIGH; cntN = whL; end else cntN = cnt - 1'b1;
      S_WHIGH: if (cnt == '0) byteDone = 1'b1; else cntN = cnt - 1'b1;
      S_RLOW:  if (cnt == '0) begin cap = 1'b1; stN = S_RHIGH; cntN = rehL; end else cntN = cnt - 1'b1;
      S_RHIGH: if (cnt == '0) byteDone = 1'b1; else cntN = cnt - 1'b1;
      S_BSYLO, S_BSYHI: begin
        toN = toCnt + 1'b1;
        if (toCnt == timeoutLim) begin errSet = 1'b1; finish = 1'b1; end
        else if (st == S_BSYLO && !rdySync) stN = S_BSYHI;
        else if (st == S_BSYHI && rdySync) advance = 1'b1;
      end
      default: stN = S_IDLE;
    endcase
    if (byteDone) begin
      if (!byteLast) begin
        idxN = idx + 1'b1;
        stN  = isRead ? S_RLOW : S_SETUP;
        cntN = isRead ? rpL : suL;
      end else if (curPhase == PH_CMD2) begin
        stN = S_BSYLO; toN = '0;
      end else advance = 1'b1;
    end
    if (advance) begin
      if (nxtOk) doLaunch = 1'b1; else finish = 1'b1;
    end
    if (doLaunch) begin
      stepN = launchStep; idxN = '0;
      if (phaseAt(launchStep, afterData) == PH_DATA && dataRx) begin
        stN = S_RLOW; cntN = rpL;
      end else begin
        stN = S_SETUP; cntN = suL;
      end
    end
    if (finish) begin stN = S_IDLE; doneSet = 1'b1; end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= S_IDLE; step <= '0; idx <= '0; cnt <= '0; toCnt <= '0;
      done <= 1'b0; timeoutErr <= 1'b0;
    end else begin
      st <= stN; step <= stepN; idx <= idxN; cnt <= cntN; toCnt <= toN;
      if (doneSet) done <= 1'b1; else if (doneClr) done <= 1'b0;
      if (errSet) timeoutErr <= 1'b1; else if (errClr) timeoutErr <= 1'b0;
    end
  end

  logic wrState;
  assign wrState = (st == S_SETUP) || (st == S_WLOW) || (st == S_WHIGH);
  assign busy = (st != S_IDLE);
  assign ceN  = !busy;
  assign cle  = wrState && (curPhase == PH_CMD1 || curPhase == PH_CMD2);
  assign ale  = wrState && (curPhase == PH_ADDR);
  assign weN  = (st != S_WLOW);
  assign reN  = (st != S_RLOW);
  assign ioOe = wrState;
  assign strb = '{clrResp: clr, capture: cap, phase: curPhase, idx: idx};
endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int HI_W  = 8,
  parameter int LANES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        cmd1,
  input  logic [7:0]        cmd2,
  input  logic [31:0]       addrLo,
  input  logic [HI_W-1:0]   addrHi,
  input  logic [8*LANES-1:0] txData,
  input  logic [7:0]        ioIn,
  input  logic              rbN,
  output logic [7:0]        ioOut,
  output logic [8*LANES-1:0] resp,
  output logic              rdySync
);
  localparam int AALL_W = 64;
  logic [AALL_W-1:0] addrAll;
  logic rbMeta;

  assign addrAll = AALL_W'({addrHi, addrLo});

  always_comb begin
    case (strb.phase)
      PH_CMD1: ioOut = cmd1;
      PH_CMD2: ioOut = cmd2;
      PH_ADDR: ioOut = addrAll[strb.idx*8 +: 8];
      default: ioOut = txData[strb.idx[$clog2(LANES)-1:0]*8 +: 8];
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resp[g*8 +: 8] <= '0;
      else if (strb.clrResp) resp[g*8 +: 8] <= '0;
      else if (strb.capture && strb.idx == 3'(g)) resp[g*8 +: 8] <= ioIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin rbMeta <= 1'b1; rdySync <= 1'b1; end
    else begin rbMeta <= rbN; rdySync <= rbMeta; end
  end
endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_seq_pkg::*;
#(
  parameter int TW  = 4,
  parameter int TOW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            go,
  input  logic            enCmd1,
  input  logic            enAddr,
  input  logic            enData,
  input  logic            enCmd2,
  input  logic            afterData,
  input  logic            dataRx,
  input  logic [2:0]      addrCnt,
  input  logic [1:0]      xferSize,
  input  logic [7:0]      cmd1,
  input  logic [7:0]      cmd2,
  input  logic [31:0]     addrLo,
  input  logic [7:0]      addrHi,
  input  logic [31:0]     txData,
  input  logic [5*TW-1:0] timing,
  input  logic [TOW-1:0]  timeoutLim,
  input  logic            doneClr,
  output logic            busy,
  output logic            done,
  output logic            timeoutErr,
  output logic            devReady,
  output logic [31:0]     resp,
  output logic            ceN,
  output logic            cle,
  output logic            ale,
  output logic            weN,
  output logic            reN,
  output logic [7:0]      ioOut,
  output logic            ioOe,
  input  logic [7:0]      ioIn,
  input  logic            rbN
);
  strobe_t strb;

  nand_seq_ctrl #(.TW(TW), .TOW(TOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .enCmd1(enCmd1), .enAddr(enAddr),
    .enData(enData), .enCmd2(enCmd2), .afterData(afterData), .dataRx(dataRx),
    .addrCnt(addrCnt), .xferSize(xferSize), .timing(timing),
    .timeoutLim(timeoutLim), .doneClr(doneClr), .rdySync(devReady),
    .busy(busy), .done(done), .timeoutErr(timeoutErr), .ceN(ceN), .cle(cle),
    .ale(ale), .weN(weN), .reN(reN), .ioOe(ioOe), .strb(strb)
  );

  nand_seq_dp #(.HI_W(8), .LANES(4)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmd1(cmd1), .cmd2(cmd2),
    .addrLo(addrLo), .addrHi(addrHi), .txData(txData), .ioIn(ioIn),
    .rbN(rbN), .ioOut(ioOut), .resp(resp), .rdySync(devReady)
  );
endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       done,
  input logic       doneClr,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       reN,
  input logic       ioOe,
  input logic [7:0] ioOut
);
  // R5, R4: latch enables are exclusive
  p_latch_excl_r4: assert property (@(posedge clk) disable iff (!rstN) !(cle && ale));
  // R10: strobes exclusive
  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rstN) weN || reN);
  // R10: bus byte steady while WE# is low
  p_io_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!weN && $past(!weN)) |-> $stable(ioOut));
  // R6: bus released during read strobes
  p_no_drive_read_r6: assert property (@(posedge clk) disable iff (!rstN) !reN |-> !ioOe);
  // R7: done holds until cleared
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rstN) (done && !doneClr) |=> done);
  // R7: completion always flags done
  p_busy_fall_done_r7: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done);
  // R1: idle pins quiet
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (weN && reN && !cle && !ale && !ioOe));
endmodule

bind nand_phase_seq nand_seq_chk u_chk (.*);

// File: tb/tb_nand_phase_seq.sv
module tb_nand_phase_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, go, enCmd1, enAddr, enData, enCmd2, afterData, dataRx, doneClr;
  logic [2:0] addrCnt; logic [1:0] xferSize;
  logic [7:0] cmd1, cmd2, addrHi, ioIn, ioOut;
  logic [31:0] addrLo, txData, resp;
  logic [19:0] timing; logic [15:0] timeoutLim;
  logic busy, done, timeoutErr, devReady, ceN, cle, ale, weN, reN, ioOe, rbN;

  nand_phase_seq dut (.*);

  int checks = 0, fails = 0, cyc = 0;
  logic [9:0] logE [0:63]; int logN;
  logic [9:0] expE [0:15]; int expN;
  logic [7:0] devBytes [0:3]; int rdN;
  int rbMode, rbPend, rbLeft; bit rbRoseSeen, earlyRead, needWait;
  bit prevWe = 1, prevRe = 1, firstFall;
  int lowCnt, weLowLast, reCnt, reLowLast, gapCnt, gapFirst, gapLast;
  logic rbModel = 1'b1, rbForceEn = 1'b0, rbForceVal = 1'b1;
  assign rbN = rbForceEn ? rbForceVal : rbModel;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
    if (!prevWe && weN) begin
      if (cle && logN > 0 && rbMode == 0) rbPend = 2;
      if (cle && logN > 0) rbRoseSeen = 0;
      if (logN < 64) logE[logN] = {cle, ale, ioOut};
      logN++;
      weLowLast = lowCnt;
    end
    if (prevWe && !weN) begin
      if (firstFall) gapFirst = gapCnt; else gapLast = gapCnt;
      firstFall = 0;
    end
    if (weN && !ceN) gapCnt++; else gapCnt = 0;
    if (!weN) lowCnt = prevWe ? 1 : lowCnt + 1;
    if (prevRe && !reN) begin
      if (needWait && !rbRoseSeen) earlyRead = 1;
      ioIn = devBytes[rdN % 4]; rdN++;
    end
    if (!reN) reCnt = prevRe ? 1 : reCnt + 1;
    if (!prevRe && reN) reLowLast = reCnt;
    if (rbPend > 0) begin
      rbPend--;
      if (rbPend == 0) begin rbModel = 1'b0; rbLeft = 5; end
    end else if (!rbModel) begin
      rbLeft--;
      if (rbLeft == 0) begin rbModel = 1'b1; rbRoseSeen = 1; end
    end
    prevWe = weN; prevRe = reN;
  end

  function automatic logic [7:0] addrByte(input int i);
    logic [63:0] a = {24'd0, addrHi, addrLo};
    return a[i*8 +: 8];
  endfunction

  task automatic pushData();
    if (enData && !dataRx)
      for (int i = 0; i <= int'(xferSize); i++) begin expE[expN] = {2'b00, txData[i*8 +: 8]}; expN++; end
  endtask

  task automatic buildExp();
    expN = 0;
    if (enCmd1) begin expE[expN] = {2'b10, cmd1}; expN++; end
    if (enAddr)
      for (int i = 0; i <= int'(addrCnt); i++) begin expE[expN] = {2'b01, addrByte(i)}; expN++; end
    if (!afterData) begin
      if (enCmd2) begin expE[expN] = {2'b10, cmd2}; expN++; end
      pushData();
    end else begin
      pushData();
      if (enCmd2) begin expE[expN] = {2'b10, cmd2}; expN++; end
    end
  endtask

  function automatic logic [31:0] expResp();
    logic [31:0] r = '0;
    if (enData && dataRx)
      for (int i = 0; i <= int'(xferSize); i++) r[i*8 +: 8] = devBytes[i];
    return r;
  endfunction

  task automatic runOp(input int goAgainAt);
    logN = 0; rdN = 0; earlyRead = 0; rbRoseSeen = 0; firstFall = 1;
    needWait = enCmd2 && enData && dataRx && !afterData;
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int n = 0; n < 5000 && busy; n++) begin
      if (n == goAgainAt) go = 1'b1; else go = 1'b0;
      @(negedge clk);
    end
    go = 1'b0;
  endtask

  task automatic checkLog(input string req);
    bit ok = (logN == expN);
    int bad = -1;
    for (int i = 0; i < expN && i < logN; i++) if (logE[i] !== expE[i] && bad < 0) bad = i;
    if (bad >= 0) ok = 0;
    if (bad >= 0) chk(ok, req, "bus entry", logE[bad], expE[bad]);
    else chk(ok, req, "bus entry count", logN, expN);
  endtask

  task automatic setOp(input bit c1, input bit ad, input bit dt, input bit c2,
                       input bit aft, input bit rx, input int ac, input int xs);
    enCmd1 = c1; enAddr = ad; enData = dt; enCmd2 = c2; afterData = aft; dataRx = rx;
    addrCnt = 3'(ac); xferSize = 2'(xs);
  endtask

  initial begin
    void'($urandom(32'd24681));
    rstN = 0; go = 0; doneClr = 0; ioIn = 0; logN = 0; rbMode = 0; rbPend = 0;
    setOp(0,0,0,0,0,0,0,0);
    cmd1 = 8'h90; cmd2 = 8'h30; addrLo = 32'h0; addrHi = 8'h0; txData = 32'h0;
    timing = {4'd1, 4'd2, 4'd2, 4'd3, 4'd2}; timeoutLim = 16'd60;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({ceN, cle, ale, weN, reN, ioOe, busy, done, timeoutErr} === 9'b100110000, "R1",
        "idle pins", {ceN, cle, ale, weN, reN, ioOe, busy, done, timeoutErr}, 9'b100110000);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R6 four-byte receive, one address byte, no trailing command
    devBytes[0] = 8'hEC; devBytes[1] = 8'hD3; devBytes[2] = 8'h51; devBytes[3] = 8'h95;
    setOp(1,1,1,0,0,1,0,3); addrLo = 32'h0; cmd1 = 8'h90;
    @(negedge clk); go = 1'b1; @(negedge clk); go = 1'b0;
    chk(busy === 1'b1 && ceN === 1'b0, "R7", "busy after go", busy, 1);
    logN = 0; rdN = 0; firstFall = 1;
    for (int n = 0; n < 2000 && busy; n++) @(negedge clk);
    buildExp(); checkLog("R5");
    chk(resp === expResp(), "R6", "4-byte pack", resp, expResp());
    chk(done === 1'b1, "R7", "done set", done, 1);
    repeat (4) @(negedge clk);
    chk(done === 1'b1, "R7", "done held", done, 1);
    doneClr = 1; @(negedge clk); doneClr = 0;
    chk(done === 1'b0, "R7", "done cleared", done, 0);

    // R6 one-byte receive clears upper lanes
    devBytes[0] = 8'hE0; setOp(1,0,1,0,0,1,0,0); cmd1 = 8'h70;
    runOp(-1);
    chk(resp === 32'h000000E0, "R6", "1-byte pack", resp, 32'h000000E0);
    chk(reLowLast == 2, "R10", "RE# low width", reLowLast, 2);

    // R2 R4 R8 R10 page read
    setOp(1,1,1,1,0,1,4,3); cmd1 = 8'h00; cmd2 = 8'h30;
    addrLo = 32'h1234_0801; addrHi = 8'h05;
    devBytes[0] = 8'h11; devBytes[1] = 8'h22; devBytes[2] = 8'h33; devBytes[3] = 8'h44;
    runOp(-1);
    buildExp(); checkLog("R2");
    chk(logE[3][7:0] === 8'h34 && logE[5] === {2'b01, 8'h05}, "R4", "address byte order",
        logE[3][7:0], 8'h34);
    chk(earlyRead == 0 && rdN == 4, "R8", "reads after ready", rdN, 4);
    chk(resp === 32'h44332211, "R6", "page read resp", resp, 32'h44332211);
    chk(weLowLast == 3, "R10", "WE# low width", weLowLast, 3);
    chk(gapFirst == 2, "R10", "setup to first WE#", gapFirst, 2);
    chk(gapLast == 4, "R10", "WE# high between strobes", gapLast, 4);
    chk(timeoutErr === 1'b0, "R9", "no timeout", timeoutErr, 0);

    // R3 program: data then trailing command
    setOp(1,1,1,1,1,0,4,3); cmd1 = 8'h80; cmd2 = 8'h10; txData = 32'hA5B6C7D8;
    runOp(-1);
    buildExp(); checkLog("R3");
    chk(logN == 11 && logE[10] === {2'b10, 8'h10}, "R3", "cmd2 last", logE[10], {2'b10, 8'h10});

    // R4 erase three address bytes
    setOp(1,1,0,1,0,0,2,0); cmd1 = 8'h60; cmd2 = 8'hD0; addrLo = 32'h00ABCDEF;
    runOp(-1);
    buildExp(); checkLog("R4");

    // R5 reset command alone
    setOp(1,0,0,0,0,0,0,0); cmd1 = 8'hFF;
    runOp(-1);
    chk(logN == 1 && logE[0] === {2'b10, 8'hFF}, "R5", "single cmd", logN, 1);

    // R9 timeout: device never goes busy
    rbMode = 1; setOp(1,1,1,1,0,1,4,3); cmd1 = 8'h00; cmd2 = 8'h30; timeoutLim = 16'd20;
    runOp(-1);
    chk(timeoutErr === 1'b1 && done === 1'b1, "R9", "timeout flag", timeoutErr, 1);
    chk(rdN == 0, "R9", "data skipped", rdN, 0);
    rbMode = 0; timeoutLim = 16'd60;
    setOp(1,0,0,0,0,0,0,0);
    runOp(-1);
    chk(timeoutErr === 1'b0, "R9", "cleared on start", timeoutErr, 0);

    // R10 zero fields act as one cycle
    timing = 20'h0; setOp(1,1,0,0,0,0,2,0); addrLo = 32'h00030201;
    runOp(-1);
    chk(weLowLast == 1 && gapFirst == 1 && gapLast == 2, "R10", "min widths",
        {weLowLast, gapFirst, gapLast}, {32'd1, 32'd1, 32'd2});

    // R12 go while busy
    timing = {4'd1, 4'd2, 4'd2, 4'd3, 4'd2};
    setOp(1,1,0,0,0,0,4,0);
    runOp(3);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && logN == 6, "R12", "no second op", logN, 6);

    // R11 synchronizer delay
    rbForceEn = 1; rbForceVal = 0;
    @(negedge clk);
    chk(devReady === 1'b1, "R11", "one edge later", devReady, 1);
    @(negedge clk);
    chk(devReady === 1'b0, "R11", "two edges later", devReady, 0);
    rbForceVal = 1; repeat (3) @(negedge clk);
    chk(devReady === 1'b1, "R11", "back ready", devReady, 1);
    rbForceEn = 0;

    // random mix, R2 R3 R6 R8
    for (int k = 0; k < 24; k++) begin
      bit prog = $urandom % 2;
      setOp(1, 1, 1, prog ? 1'b1 : 1'($urandom % 2), prog, !prog,
            int'($urandom % 5), int'($urandom % 4));
      cmd1 = 8'($urandom); cmd2 = 8'($urandom); addrLo = $urandom; addrHi = 8'($urandom);
      txData = $urandom; timing = 20'($urandom) & 20'h33333;
      for (int b = 0; b < 4; b++) devBytes[b] = 8'($urandom);
      runOp(-1);
      buildExp(); checkLog(prog ? "R3" : "R2");
      if (!prog) chk(resp === expResp() && earlyRead == 0, "R6", "random resp", resp, expResp());
      chk(done === 1'b1 && timeoutErr === 1'b0, "R7", "random done", done, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule